// File: doc/BRIEF.md
# Snoop-Gated Mezzanine Site Bridge

This block is a slave on a 32-bit local processor bus. It answers read, write and interrupt-acknowledge cycles that fall inside its address window. It turns each one into one or two handshaked cycles on four 16-bit mezzanine module sites (a, b, c, d). A small register space holds one control byte per site and a module-cycle timeout limit. Bit 0 of the control byte for site a joins sites a and b into one 32-bit module. Bit 0 for site c does the same for sites c and d.

Before it starts a module cycle or drives any response, the bridge passes the request through a coherency gate. If the cycle is marked snoop-inhibited, the memory-inhibit line is ignored. Otherwise the bridge holds the cycle until memory-inhibit is released. If another slave terminates the cycle while the bridge is still waiting, the bridge quietly drops the request.

A module cycle raises the select strobe of each site involved and waits until every one of those sites acknowledges. If the acknowledge does not arrive within the programmed number of cycles, the cycle ends in an error acknowledge.

Top module: `mzb_bridge`

## Requirements
- R1: A start whose address bits [31:16] differ from WIN_BASE produces no strobe, no `lb_ta` and no `lb_tea`.
- R2: When `lb_snoop_inh` is high at start, the bridge ignores `lb_mi_n` and raises the site strobe one clock after the start is taken.
- R3: When `lb_snoop_inh` is low at start, no strobe, `lb_ta` or `lb_tea` appears while `lb_mi_n` is low. The strobe rises in the clock after `lb_mi_n` goes high.
- R4: While the bridge waits on memory-inhibit, a high `lb_ta_other` or `lb_tea_other` makes it abandon the cycle: no strobe, no response, and the next cycle is served normally. This holds even when `lb_mi_n` rises in that same clock.
- R5: A 32-bit access (`lb_half`=0) to an unpaired site makes two module cycles on that site, at half-word offsets N and N+1. The first carries bits [31:16] and the second bits [15:0].
- R6: With bit 0 set in the control byte of site a (or c), a 32-bit access to that pair makes one module cycle with both strobes (0011 or 1100). The lower site carries bits [31:16] and the higher site bits [15:0].
- R7: Bit 0 of the control byte of site b or d reads back as written but does not change how an access is split.
- R8: A 16-bit read returns its data on lanes [31:16] when address bit 1 is 0, and on lanes [15:0] when it is 1. The other lanes read as zero.
- R9: A successful cycle raises `lb_ta` for exactly one clock.
- R10: With timeout limit T, a cycle that is never acknowledged holds its strobe for T+1 clocks and then raises `lb_tea` for one clock, with no `lb_ta`.
- R11: Register space (address bit 15 = 1) holds five bytes at index `lb_addr[4:2]`: sites a–d at 0–3 and the timeout limit at 4, which resets to TMO_RESET. Bytes for c and d read and write like those for a and b, and the read data appears on lanes [7:0].
- R12: An interrupt-acknowledge access becomes a module read cycle with `mod_iack` high alongside the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lb_start | input | 1 | One-clock transfer start |
| lb_addr | input | 32 | Byte address: [31:16] window, [15] register space, [14:13] site, [12:1] half-word offset, [4:2] register index |
| lb_rd | input | 1 | 1 = read, 0 = write |
| lb_iack | input | 1 | Interrupt-acknowledge cycle |
| lb_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| lb_wdata | input | 32 | Write data |
| lb_snoop_inh | input | 1 | Cycle is marked snoop-inhibited |
| lb_mi_n | input | 1 | Memory inhibit, low = asserted |
| lb_ta_other | input | 1 | Transfer acknowledge from another slave |
| lb_tea_other | input | 1 | Transfer error acknowledge from another slave |
| lb_rdata | output | 32 | Read data, valid with lb_ta |
| lb_ta | output | 1 | Transfer acknowledge |
| lb_tea | output | 1 | Transfer error acknowledge |
| mod_sel | output | 4 | Per-site select strobe |
| mod_addr | output | 12 | Half-word offset on the module side |
| mod_rd | output | 1 | Module cycle direction, 1 = read |
| mod_iack | output | 1 | Module interrupt-acknowledge cycle |
| mod_wdata | output | 64 | Write data, 16 bits per site (site s at [16s+15:16s]) |
| mod_rdata | input | 64 | Read data, 16 bits per site |
| mod_ack | input | 4 | Per-site acknowledge |

## Verification
The release of memory-inhibit and a termination by another slave can land in the same clock while the bridge waits in its gate. The bench provokes this by raising `lb_mi_n` and `lb_ta_other` on the same falling edge. It then judges the result at the ports: the cycle must be abandoned, with no strobe and no acknowledge in the following clocks, and a later register read must complete normally. A second case pairs a `lb_tea_other` with a held memory-inhibit, to show that either foreign termination wins over the wait.

// File: rtl/mzb_pkg.sv
// Shared constants and types for the mezzanine site bridge.
// Assumes a 32-bit local bus and four 16-bit sites.
package mzb_pkg;
    localparam int LB_W      = 32;
    localparam int HALF_W    = 16;
    localparam int SITES     = 4;
    localparam int SITE_W    = $clog2(SITES);
    localparam int OFS_W     = 12;
    localparam int REG_W     = 8;
    localparam int RIDX_W    = 3;
    localparam int REG_BIT   = 15;
    localparam int SITE_LSB  = 13;
    localparam int MODD_W    = SITES * HALF_W;

    typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_BUSY, ST_GAP} st_t;

    typedef struct packed {
        logic              is_reg;
        logic [SITE_W-1:0] site;
        logic [OFS_W-1:0]  ofs;
        logic [RIDX_W-1:0] ridx;
        logic              rd;
        logic              iack;
        logic              half;
        logic              snp_inh;
        logic [LB_W-1:0]   wdata;
    } req_t;
endpackage

// File: rtl/mzb_snoop_gate.sv
// Coherency gate: decides each clock whether a waiting request may
// proceed or must be dropped. Assumes termination by another slave
// takes priority over a same-clock release of memory inhibit.
module mzb_snoop_gate (
    input  logic armed,
    input  logic snp_inh,
    input  logic mi_n,
    input  logic ta_other,
    input  logic tea_other,
    output logic go,
    output logic drop
);
    // Drop on foreign termination unless snooping is inhibited; else go when clear.
    always_comb begin
        drop = armed && !snp_inh && (ta_other || tea_other);
        go   = armed && !drop && (snp_inh || mi_n);
    end
endmodule

// File: rtl/mzb_site_regs.sv
// Control byte per site plus the timeout limit. Bit 0 of a site byte
// is the wide flag; only the even sites' flags pair sites.
module mzb_site_regs
    import mzb_pkg::*;
#(
    parameter logic [REG_W-1:0] TMO_RESET = 8'd15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] idx,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [SITES-1:0]  wide,
    output logic [REG_W-1:0]  tmo
);
    logic [REG_W-1:0] site_q [SITES];

    for (genvar s = 0; s < SITES; s++) begin : g_site
        // Holds the control byte of one site.
        always_ff @(posedge clk) begin
            if (!rst_n)
                site_q[s] <= '0;
            else if (wr_en && idx == RIDX_W'(s))
                site_q[s] <= wdata;
        end
        assign wide[s] = site_q[s][0];
    end

    // Holds the module-cycle timeout limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo <= TMO_RESET;
        else if (wr_en && idx == RIDX_W'(SITES))
            tmo <= wdata;
    end

    // Read mux over the five bytes; unused indices read zero.
    always_comb begin
        rdata = '0;
        if (idx < RIDX_W'(SITES))
            rdata = site_q[idx[SITE_W-1:0]];
        else if (idx == RIDX_W'(SITES))
            rdata = tmo;
    end
endmodule

// File: rtl/mzb_lane_map.sv
// Works out strobe mask, data half and beat count for one beat of a
// module access. Assumes pairs are a/b and c/d, keyed by the even site.
module mzb_lane_map
    import mzb_pkg::*;
(
    input  logic [SITE_W-1:0] site,
    input  logic [SITES-1:0]  wide,
    input  logic              half,
    input  logic              addr1,
    input  logic              beat,
    output logic [SITES-1:0]  mask,
    output logic [SITE_W-1:0] cur_site,
    output logic [SITE_W-1:0] base,
    output logic              upper,
    output logic              pair32,
    output logic              last
);
    logic paired;

    // Selects the site(s) and data half for the current beat.
    always_comb begin
        base     = {site[SITE_W-1:1], 1'b0};
        paired   = wide[base];
        pair32   = paired && !half;
        cur_site = site;
        upper    = !addr1;
        last     = 1'b1;
        if (pair32) begin
            upper = 1'b1;
        end else if (paired) begin
            cur_site = {site[SITE_W-1:1], addr1};
        end else if (!half) begin
            upper = !beat;
            last  = beat;
        end
        mask = '0;
        mask[cur_site] = 1'b1;
        if (pair32)
            mask[base + SITE_W'(1)] = 1'b1;
    end
endmodule

// File: rtl/mzb_bridge.sv
// Local-bus slave that gates each cycle on snoop/memory-inhibit state,
// then runs one or two strobe/acknowledge cycles on the module sites.
// Assumes lb_start is a one-clock pulse and one cycle at a time.
module mzb_bridge
    import mzb_pkg::*;
#(
    parameter logic [15:0]      WIN_BASE  = 16'hC2A0,
    parameter logic [REG_W-1:0] TMO_RESET = 8'd15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_start,
    input  logic [LB_W-1:0]   lb_addr,
    input  logic              lb_rd,
    input  logic              lb_iack,
    input  logic              lb_half,
    input  logic [LB_W-1:0]   lb_wdata,
    input  logic              lb_snoop_inh,
    input  logic              lb_mi_n,
    input  logic              lb_ta_other,
    input  logic              lb_tea_other,
    output logic [LB_W-1:0]   lb_rdata,
    output logic              lb_ta,
    output logic              lb_tea,
    output logic [SITES-1:0]  mod_sel,
    output logic [OFS_W-1:0]  mod_addr,
    output logic              mod_rd,
    output logic              mod_iack,
    output logic [MODD_W-1:0] mod_wdata,
    input  logic [MODD_W-1:0] mod_rdata,
    input  logic [SITES-1:0]  mod_ack
);
    st_t                st_q;
    req_t               req_q;
    logic               beat_q;
    logic [REG_W-1:0]   cnt_q;
    logic [LB_W-1:0]    acc_q;

    logic               hit, go, drop, reg_wr;
    logic [REG_W-1:0]   reg_rdata, tmo;
    logic [SITES-1:0]   wide, mask;
    logic [SITE_W-1:0]  cur_site, base;
    logic               upper, pair32, last;
    logic [MODD_W-1:0]  wlanes;
    logic [HALF_W-1:0]  rd_cur, rd_lo, rd_hi;
    logic [LB_W-1:0]    acc_next;
    logic [OFS_W-1:0]   beat_ofs;

    assign hit    = lb_start && (lb_addr[LB_W-1:16] == WIN_BASE);
    assign reg_wr = (st_q == ST_GATE) && go && req_q.is_reg && !req_q.rd;

    mzb_snoop_gate u_gate (
        .armed    (st_q == ST_GATE),
        .snp_inh  (req_q.snp_inh),
        .mi_n     (lb_mi_n),
        .ta_other (lb_ta_other),
        .tea_other(lb_tea_other),
        .go       (go),
        .drop     (drop)
    );

    mzb_site_regs #(.TMO_RESET(TMO_RESET)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .idx   (req_q.ridx),
        .wdata (req_q.wdata[REG_W-1:0]),
        .rdata (reg_rdata),
        .wide  (wide),
        .tmo   (tmo)
    );

    mzb_lane_map u_map (
        .site    (req_q.site),
        .wide    (wide),
        .half    (req_q.half),
        .addr1   (req_q.ofs[0]),
        .beat    (beat_q),
        .mask    (mask),
        .cur_site(cur_site),
        .base    (base),
        .upper   (upper),
        .pair32  (pair32),
        .last    (last)
    );

    for (genvar s = 0; s < SITES; s++) begin : g_wlane
        // Steers the right write half onto each selected site lane.
        always_comb begin
            wlanes[s*HALF_W +: HALF_W] = '0;
            if (mask[s]) begin
                if (pair32)
                    wlanes[s*HALF_W +: HALF_W] = (s % 2 == 0) ? req_q.wdata[31:16] : req_q.wdata[15:0];
                else
                    wlanes[s*HALF_W +: HALF_W] = upper ? req_q.wdata[31:16] : req_q.wdata[15:0];
            end
        end
    end

    // Picks returned words and merges them into the read accumulator.
    always_comb begin
        rd_cur   = mod_rdata[{cur_site, 4'b0} +: HALF_W];
        rd_lo    = mod_rdata[{base, 4'b0} +: HALF_W];
        rd_hi    = mod_rdata[{base + SITE_W'(1), 4'b0} +: HALF_W];
        beat_ofs = req_q.half ? req_q.ofs : {req_q.ofs[OFS_W-1:1], beat_q};
        if (pair32)
            acc_next = {rd_lo, rd_hi};
        else if (upper)
            acc_next = {rd_cur, acc_q[15:0]};
        else
            acc_next = {acc_q[31:16], rd_cur};
    end

    // Main sequencer: accept, gate, run module beats, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            req_q     <= '0;
            beat_q    <= 1'b0;
            cnt_q     <= '0;
            acc_q     <= '0;
            lb_rdata  <= '0;
            lb_ta     <= 1'b0;
            lb_tea    <= 1'b0;
            mod_sel   <= '0;
            mod_addr  <= '0;
            mod_rd    <= 1'b0;
            mod_iack  <= 1'b0;
            mod_wdata <= '0;
        end else begin
            lb_ta  <= 1'b0;
            lb_tea <= 1'b0;
            case (st_q)
                ST_IDLE: if (hit) begin
                    req_q.is_reg  <= lb_addr[REG_BIT];
                    req_q.site    <= lb_addr[SITE_LSB +: SITE_W];
                    req_q.ofs     <= lb_addr[OFS_W:1];
                    req_q.ridx    <= lb_addr[4:2];
                    req_q.rd      <= lb_rd || lb_iack;
                    req_q.iack    <= lb_iack;
                    req_q.half    <= lb_half;
                    req_q.snp_inh <= lb_snoop_inh;
                    req_q.wdata   <= lb_wdata;
                    beat_q        <= 1'b0;
                    acc_q         <= '0;
                    st_q          <= ST_GATE;
                end
                ST_GATE: if (drop) begin
                    st_q <= ST_IDLE;
                end else if (go && req_q.is_reg) begin
                    lb_ta    <= 1'b1;
                    lb_rdata <= req_q.rd ? {{(LB_W-REG_W){1'b0}}, reg_rdata} : '0;
                    st_q     <= ST_IDLE;
                end else if (go) begin
                    mod_sel   <= mask;
                    mod_addr  <= beat_ofs;
                    mod_wdata <= wlanes;
                    mod_rd    <= req_q.rd;
                    mod_iack  <= req_q.iack;
                    cnt_q     <= '0;
                    st_q      <= ST_BUSY;
                end
                ST_BUSY: if ((mod_ack & mod_sel) == mod_sel) begin
                    mod_sel  <= '0;
                    mod_iack <= 1'b0;
                    acc_q    <= acc_next;
                    if (last) begin
                        lb_ta    <= 1'b1;
                        lb_rdata <= req_q.rd ? acc_next : '0;
                        st_q     <= ST_IDLE;
                    end else begin
                        beat_q <= 1'b1;
                        st_q   <= ST_GAP;
                    end
                end else if (cnt_q >= tmo) begin
                    lb_tea   <= 1'b1;
                    mod_sel  <= '0;
                    mod_iack <= 1'b0;
                    st_q     <= ST_IDLE;
                end else begin
                    cnt_q <= cnt_q + REG_W'(1);
                end
                ST_GAP: begin
                    mod_sel   <= mask;
                    mod_addr  <= beat_ofs;
                    mod_wdata <= wlanes;
                    mod_iack  <= req_q.iack;
                    cnt_q     <= '0;
                    st_q      <= ST_BUSY;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    a_r9_ta_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        lb_ta |=> !lb_ta) else $error("R9 lb_ta longer than one clock");

    a_r10_tea_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        lb_tea |=> !lb_tea) else $error("R10 lb_tea longer than one clock");

    a_r10_tea_without_ta: assert property (@(posedge clk) disable iff (!rst_n)
        lb_tea |-> !lb_ta) else $error("R10 lb_tea with lb_ta");

    a_r3_hold_while_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GATE && !req_q.snp_inh && !lb_mi_n && !lb_ta_other && !lb_tea_other)
        |=> (mod_sel == '0 && !lb_ta && !lb_tea))
        else $error("R3 response while memory inhibit held");

    a_r4_abandon_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GATE && !req_q.snp_inh && (lb_ta_other || lb_tea_other))
        |=> (st_q == ST_IDLE && mod_sel == '0 && !lb_ta && !lb_tea))
        else $error("R4 cycle not abandoned");

    a_r6_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel != '0) |-> ($countones(mod_sel) == 1 || mod_sel == 4'b0011 || mod_sel == 4'b1100))
        else $error("R6 illegal strobe combination");

    a_r12_iack_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        mod_iack |-> (mod_rd && mod_sel != '0))
        else $error("R12 iack without read strobe");
endmodule

// File: tb/mzb_bridge_bench.sv
module mzb_bridge_bench;
    localparam logic [15:0] WIN = 16'hC2A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lb_start = 0, lb_rd = 0, lb_iack = 0, lb_half = 0;
    logic [31:0] lb_addr = '0, lb_wdata = '0;
    logic        lb_snoop_inh = 0, lb_mi_n = 1, lb_ta_other = 0, lb_tea_other = 0;
    logic [31:0] lb_rdata;
    logic        lb_ta, lb_tea;
    logic [3:0]  mod_sel;
    logic [11:0] mod_addr;
    logic        mod_rd, mod_iack;
    logic [63:0] mod_wdata;
    logic [63:0] mod_rdata = '0;
    logic [3:0]  mod_ack = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mzb_bridge #(.WIN_BASE(WIN), .TMO_RESET(8'd15)) u_mzb_bridge (
        .clk(clk), .rst_n(rst_n), .lb_start(lb_start), .lb_addr(lb_addr), .lb_rd(lb_rd),
        .lb_iack(lb_iack), .lb_half(lb_half), .lb_wdata(lb_wdata), .lb_snoop_inh(lb_snoop_inh),
        .lb_mi_n(lb_mi_n), .lb_ta_other(lb_ta_other), .lb_tea_other(lb_tea_other),
        .lb_rdata(lb_rdata), .lb_ta(lb_ta), .lb_tea(lb_tea), .mod_sel(mod_sel),
        .mod_addr(mod_addr), .mod_rd(mod_rd), .mod_iack(mod_iack), .mod_wdata(mod_wdata),
        .mod_rdata(mod_rdata), .mod_ack(mod_ack)
    );

    // Module-side responder and beat log.
    logic [15:0] rd_base [4] = '{16'hA1A1, 16'hB2B2, 16'hC3C3, 16'hD4D4};
    logic [3:0]  prev_sel = '0;
    bit          mute = 0;
    int          n_log = 0;
    logic [3:0]  log_sel  [8];
    logic [11:0] log_addr [8];
    logic [63:0] log_w    [8];
    logic        log_rd   [8];
    logic        log_iack [8];

    always @(negedge clk) begin
        for (int s = 0; s < 4; s++) begin
            mod_ack[s] = mod_sel[s] && prev_sel[s] && !mute;
            mod_rdata[s*16 +: 16] = rd_base[s] ^ {4'h0, mod_addr};
        end
        if ((mod_sel & ~prev_sel) != 0 && n_log < 8) begin
            log_sel[n_log] = mod_sel; log_addr[n_log] = mod_addr; log_w[n_log] = mod_wdata;
            log_rd[n_log] = mod_rd; log_iack[n_log] = mod_iack;
            n_log++;
        end
        prev_sel = mod_sel;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] maddr(input int site, input logic [11:0] ofs);
        return {WIN, 1'b0, site[1:0], ofs, 1'b0};
    endfunction

    function automatic logic [31:0] raddr(input int idx);
        return {WIN, 1'b1, 10'd0, idx[2:0], 2'b00};
    endfunction

    task automatic issue(input logic [31:0] a, input bit rd, input bit iack, input bit half,
                         input logic [31:0] wd, input bit snp);
        @(negedge clk);
        n_log = 0;
        lb_addr = a; lb_rd = rd; lb_iack = iack; lb_half = half; lb_wdata = wd;
        lb_snoop_inh = snp; lb_start = 1;
        @(negedge clk);
        lb_start = 0;
    endtask

    // Waits for a response; checks R9/R10 one-clock width.
    task automatic finish_cyc(output logic [31:0] rd, output bit ta, output bit tea);
        int k = 0;
        while (!(lb_ta || lb_tea) && k < 100) begin @(negedge clk); k++; end
        rd = lb_rdata; ta = lb_ta; tea = lb_tea;
        @(negedge clk);
        if (ta) chk(!lb_ta, "R9 ta width", {63'd0, lb_ta}, 64'd0);
        if (tea) chk(!lb_tea, "R10 tea width", {63'd0, lb_tea}, 64'd0);
    endtask

    task automatic reg_wr(input int idx, input logic [7:0] v);
        logic [31:0] rd; bit ta, tea;
        issue(raddr(idx), 0, 0, 1, {24'd0, v}, 1);
        finish_cyc(rd, ta, tea);
        chk(ta, "R11 reg write ack", {63'd0, ta}, 64'd1);
    endtask

    task automatic reg_rd(input int idx, output logic [31:0] v);
        bit ta, tea;
        issue(raddr(idx), 1, 0, 1, 0, 1);
        finish_cyc(v, ta, tea);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(!lb_ta && !lb_tea && mod_sel == 0, "R9 reset idle", {59'd0, lb_ta, lb_tea, mod_sel}, 64'd0);
        reg_rd(4, v);
        chk(v == 32'd15, "R11 timeout reset", {32'd0, v}, 64'd15);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_wr(2, 8'hA4);
        reg_wr(3, 8'h5B);
        reg_rd(2, v); chk(v == 32'hA4, "R11 site c byte", {32'd0, v}, 64'hA4);
        reg_rd(3, v); chk(v == 32'h5B, "R7 R11 site d byte", {32'd0, v}, 64'h5B);
    endtask

    task automatic t_window();
        bit seen = 0;
        issue({16'h1234, 1'b0, 2'd1, 12'h004, 1'b0}, 1, 0, 1, 0, 1);
        for (int i = 0; i < 10; i++) begin
            if (lb_ta || lb_tea || mod_sel != 0) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R1 outside window", {63'd0, seen}, 64'd0);
    endtask

    task automatic t_split();
        logic [31:0] rd; bit ta, tea;
        logic [31:0] exp = {rd_base[3] ^ 16'h0010, rd_base[3] ^ 16'h0011};
        issue(maddr(3, 12'h010), 1, 0, 0, 0, 1);
        finish_cyc(rd, ta, tea);
        chk(ta && rd == exp, "R5 R7 split read data", {32'd0, rd}, {32'd0, exp});
        chk(n_log == 2, "R5 R7 two beats", n_log, 2);
        chk(log_sel[0] == 4'b1000 && log_addr[0] == 12'h010 && log_sel[1] == 4'b1000 && log_addr[1] == 12'h011,
            "R5 beat order", {40'd0, log_sel[0], log_addr[0], log_addr[1]}, {40'd0, 4'b1000, 12'h010, 12'h011});
        issue(maddr(3, 12'h030), 0, 0, 0, 32'hCAFE_F00D, 1);
        finish_cyc(rd, ta, tea);
        chk(n_log == 2 && log_w[0][63:48] == 16'hCAFE && log_w[1][63:48] == 16'hF00D,
            "R5 split write halves", {log_w[0][63:48], log_w[1][63:48], 32'(n_log)}, {16'hCAFE, 16'hF00D, 32'd2});
    endtask

    task automatic t_lanes();
        logic [31:0] rd; bit ta, tea;
        logic [31:0] e;
        issue(maddr(1, 12'h021), 1, 0, 1, 0, 1);
        finish_cyc(rd, ta, tea);
        e = {16'h0, rd_base[1] ^ 16'h0021};
        chk(ta && rd == e && n_log == 1 && log_sel[0] == 4'b0010, "R8 low lanes", {32'd0, rd}, {32'd0, e});
        issue(maddr(1, 12'h020), 1, 0, 1, 0, 1);
        finish_cyc(rd, ta, tea);
        e = {rd_base[1] ^ 16'h0020, 16'h0};
        chk(ta && rd == e, "R8 high lanes", {32'd0, rd}, {32'd0, e});
    endtask

    task automatic t_pair();
        logic [31:0] rd; bit ta, tea;
        logic [31:0] e;
        reg_wr(0, 8'h01);
        issue(maddr(0, 12'h040), 0, 0, 0, 32'h1234_5678, 1);
        finish_cyc(rd, ta, tea);
        chk(ta && n_log == 1 && log_sel[0] == 4'b0011, "R6 pair single beat", {56'd0, 4'(n_log), log_sel[0]}, {56'd0, 4'd1, 4'b0011});
        chk(log_w[0][31:0] == 32'h5678_1234, "R6 pair write lanes", {32'd0, log_w[0][31:0]}, 64'h5678_1234);
        issue(maddr(0, 12'h040), 1, 0, 0, 0, 1);
        finish_cyc(rd, ta, tea);
        e = {rd_base[0] ^ 16'h0040, rd_base[1] ^ 16'h0040};
        chk(ta && rd == e, "R6 pair read order", {32'd0, rd}, {32'd0, e});
        reg_wr(0, 8'h00);
    endtask

    task automatic t_iack();
        logic [31:0] rd; bit ta, tea;
        issue(maddr(2, 12'h007), 0, 1, 1, 0, 1);
        finish_cyc(rd, ta, tea);
        chk(ta && n_log == 1 && log_iack[0] && log_rd[0] && log_sel[0] == 4'b0100, "R12 iack cycle",
            {60'd0, ta, log_iack[0], log_rd[0], 1'b0}, {60'd0, 4'b1110});
    endtask

    task automatic t_snoop_inh();
        logic [31:0] rd; bit ta, tea;
        lb_mi_n = 0;
        issue(maddr(1, 12'h002), 1, 0, 1, 0, 1);
        @(negedge clk);
        chk(mod_sel == 4'b0010, "R2 strobe despite inhibit", {60'd0, mod_sel}, 64'b0010);
        finish_cyc(rd, ta, tea);
        chk(ta, "R2 completes", {63'd0, ta}, 64'd1);
        lb_mi_n = 1;
    endtask

    task automatic t_mi_wait();
        logic [31:0] rd; bit ta, tea; bit seen = 0;
        lb_mi_n = 0;
        issue(maddr(0, 12'h004), 1, 0, 1, 0, 0);
        for (int i = 0; i < 6; i++) begin
            if (lb_ta || lb_tea || mod_sel != 0) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R3 held under inhibit", {63'd0, seen}, 64'd0);
        lb_mi_n = 1;
        @(negedge clk);
        chk(mod_sel == 4'b0001, "R3 strobe after release", {60'd0, mod_sel}, 64'b0001);
        finish_cyc(rd, ta, tea);
        chk(ta, "R3 completes", {63'd0, ta}, 64'd1);
    endtask

    task automatic t_abandon(input bit use_tea, input bit same_release);
        logic [31:0] v; bit seen = 0;
        lb_mi_n = 0;
        issue(maddr(2, 12'h001), 1, 0, 1, 0, 0);
        if (!same_release) begin @(negedge clk); @(negedge clk); end
        if (use_tea) lb_tea_other = 1; else lb_ta_other = 1;
        if (same_release) lb_mi_n = 1;
        @(negedge clk);
        lb_ta_other = 0; lb_tea_other = 0; lb_mi_n = 1;
        for (int i = 0; i < 8; i++) begin
            if (lb_ta || lb_tea || mod_sel != 0) seen = 1;
            @(negedge clk);
        end
        chk(!seen && n_log == 0, "R4 abandoned quietly", {63'd0, seen}, 64'd0);
        reg_rd(2, v);
        chk(v == 32'hA4, "R4 idle afterwards", {32'd0, v}, 64'hA4);
    endtask

    task automatic t_timeout();
        logic [31:0] rd; int on = 0; int k = 0; bit ta_seen = 0;
        reg_wr(4, 8'd4);
        mute = 1;
        issue(maddr(0, 12'h008), 1, 0, 1, 0, 1);
        while (!lb_tea && k < 100) begin
            if (mod_sel != 0) on++;
            if (lb_ta) ta_seen = 1;
            @(negedge clk); k++;
        end
        chk(lb_tea && !lb_ta && !ta_seen, "R10 error ack", {62'd0, lb_tea, ta_seen}, 64'b10);
        chk(on == 5, "R10 strobe length", on, 5);
        @(negedge clk);
        chk(!lb_tea && mod_sel == 0, "R10 tea width", {59'd0, lb_tea, mod_sel}, 64'd0);
        mute = 0;
        reg_wr(4, 8'd15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_window();
        t_split();
        t_lanes();
        t_pair();
        t_iack();
        t_snoop_inh();
        t_mi_wait();
        t_abandon(0, 0);
        t_abandon(1, 0);
        t_abandon(0, 1);
        t_timeout();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule